// File: doc/BRIEF.md
# Multi-Slope Global Shutter Sequencer

This block sequences one exposure of an image sensor that runs a global shutter with multiple-slope integration. A frame trigger starts the exposure. The block then issues a start-shutter pulse for each slope and a stop-shutter pulse at the end. Every interval comes from the block's own counters, because the sensor's timeout flag is not usable in this mode. The number of slopes is programmable from one to four, and each slope has its own length in system clocks.

Between start pulses the block requests register writes to a separate interface block. These writes program the kneepoint setting that lowers the pixel reset voltage for the next slope. After the last start pulse it requests one more write that clears the setting. Each write must be finished a guard time before the next shutter pulse. The guard time depends on the granularity code. The time a write takes depends on whether the parallel or the serial interface is in use. When a used slope is too short to hold a write plus the guard time, the trigger is refused and no pulse is issued.

Top module: `ms_shutter_seq`

## Requirements
- R1: When the block is idle and the configuration is valid, a trigger sampled at a clock edge raises `start_o` and `busy_o` in the cycle after that edge.
- R2: With S = `slope_cnt_i`+1 slopes and lengths L0..L(S-1), where Lk is in bits [16k+15:16k] of `slope_len_i`, pulse k+1 comes exactly Lk cycles after start pulse k. Pulses 1..S-1 are start pulses, and pulse S is the single stop pulse.
- R3: `start_o` and `stop_o` are each one cycle wide and are never high together.
- R4: When S>1, one cycle after start pulse k (for k < S-1) the block raises `wr_req_o` for one cycle with `wr_addr_o` = KNEE_ADDR. The data carries the kneepoint code k+1 in bits [1:0] and a 1 in the enable bit, bit 2. All other data bits are 0.
- R5: When S>1, one cycle after the last start pulse the block writes code 00 with enable 0 to the same address. This write comes before the stop pulse.
- R6: When S=1, no write is requested during the exposure.
- R7: The minimum slope length is UPL_PAR (when `serial_mode_i`=0) or UPL_SER (when it is 1), plus 5·N, plus 1. Here N = 32·2^`gran_i` (32, 64, 128 or 256). A slope exactly at this minimum is accepted.
- R8: If any used slope is shorter than the minimum, `cfg_err_o` pulses for one cycle in the cycle after the trigger edge. No shutter pulse or write follows, and `busy_o` stays low. The lengths of unused slopes are not checked.
- R9: `busy_o` falls one cycle after the stop pulse. A trigger that arrives while `busy_o` is high, or in the cycle it falls, is ignored.
- R10: The slope count and lengths are captured at the accepted trigger. Changing them during an exposure has no effect on that exposure.
- R11: While reset is held, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Frame trigger |
| slope_cnt_i | input | 2 | Number of slopes minus one |
| slope_len_i | input | 64 | Four 16-bit slope lengths in clocks, slope 0 in the low bits |
| gran_i | input | 2 | Granularity code that selects N |
| serial_mode_i | input | 1 | 1 selects the serial upload time, 0 the parallel upload time |
| start_o | output | 1 | Start-shutter pulse |
| stop_o | output | 1 | Stop-shutter pulse |
| wr_req_o | output | 1 | Register write request |
| wr_addr_o | output | 8 | Write address |
| wr_data_o | output | 8 | Write data: kneepoint code in bits [1:0], enable in bit 2 |
| busy_o | output | 1 | Exposure in progress |
| cfg_err_o | output | 1 | Trigger refused because of a short slope |

## Verification
Every output is registered, so the results of an accepted trigger begin one edge after the trigger is sampled. At that edge the first start pulse, busy and any error flag change. Each write follows its start pulse by one further cycle. Every later pulse follows the one before it by exactly the programmed slope length. Busy falls one edge after the stop pulse. At each accepted trigger the bench schedules these events at absolute cycle numbers. On every falling edge it compares all outputs against the schedule for the current cycle, so an event that arrives early, late or in extra is seen in the cycle where it occurs.

// File: rtl/ms_shutter_pkg.sv
package ms_shutter_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_FIN  = 2'd2
  } seq_state_t;

endpackage

// File: rtl/ms_min_interval.sv
// Shortest legal slope: upload time for the selected interface,
// guard time scaled by granularity, plus the one cycle between a
// start pulse and its write request.
module ms_min_interval #(
  parameter int LW          = 16,
  parameter int UPL_PAR     = 40,
  parameter int UPL_SER     = 320,
  parameter int GRAN_BASE   = 32,
  parameter int STABLE_MULT = 5
) (
  input  logic [1:0]    gran_i,
  input  logic          serial_i,
  output logic [LW-1:0] min_o
);

  localparam logic [LW-1:0] UP_P  = LW'(UPL_PAR);
  localparam logic [LW-1:0] UP_S  = LW'(UPL_SER);
  localparam logic [LW-1:0] BASE  = LW'(GRAN_BASE);
  localparam logic [LW-1:0] MULT  = LW'(STABLE_MULT);

  logic [LW-1:0] n_gran;
  logic [LW-1:0] t_stable;
  logic [LW-1:0] t_upload;

  always_comb begin
    n_gran   = BASE << gran_i;
    t_stable = n_gran * MULT;
    t_upload = serial_i ? UP_S : UP_P;
    min_o    = t_upload + t_stable + LW'(1);
  end

endmodule

// File: rtl/ms_cfg_check.sv
// Checks every used slope against the minimum length.
module ms_cfg_check #(
  parameter int NSLOPE = 4,
  parameter int LW     = 16,
  localparam int SW    = $clog2(NSLOPE)
) (
  input  logic [NSLOPE*LW-1:0] len_i,
  input  logic [SW-1:0]        last_i,
  input  logic [LW-1:0]        min_i,
  output logic                 ok_o
);

  logic [NSLOPE-1:0] short_used;

  for (genvar k = 0; k < NSLOPE; k++) begin : g_slope
    logic [LW-1:0] len_k;
    assign len_k         = len_i[k*LW +: LW];
    assign short_used[k] = (SW'(k) <= last_i) && (len_k < min_i);
  end

  assign ok_o = ~|short_used;

endmodule

// File: rtl/ms_interval_cnt.sv
// Down counter that times one slope.
module ms_interval_cnt #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [LW-1:0] load_val_i,
  output logic          zero_o
);

  logic [LW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load_i) begin
      cnt <= load_val_i;
    end else if (cnt != '0) begin
      cnt <= cnt - LW'(1);
    end
  end

  assign zero_o = (cnt == '0);

  // R2: an idle counter stays at zero and does not wrap
  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!load_i && zero_o) |=> zero_o);

endmodule

// File: rtl/ms_shutter_seq.sv
module ms_shutter_seq
  import ms_shutter_pkg::*;
#(
  parameter int NSLOPE    = 4,
  parameter int LW        = 16,
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int KNEE_ADDR = 8'h42,
  parameter int UPL_PAR   = 40,
  parameter int UPL_SER   = 320,
  localparam int SW       = $clog2(NSLOPE)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 trig_i,
  input  logic [SW-1:0]        slope_cnt_i,
  input  logic [NSLOPE*LW-1:0] slope_len_i,
  input  logic [1:0]           gran_i,
  input  logic                 serial_mode_i,
  output logic                 start_o,
  output logic                 stop_o,
  output logic                 wr_req_o,
  output logic [AW-1:0]        wr_addr_o,
  output logic [DW-1:0]        wr_data_o,
  output logic                 busy_o,
  output logic                 cfg_err_o
);

  seq_state_t     state;
  logic [LW-1:0]  len_arr [NSLOPE];
  logic [LW-1:0]  lat     [NSLOPE];
  logic [SW-1:0]  idx;
  logic [SW-1:0]  last;
  logic [SW-1:0]  nxt_idx;
  logic           wr_pend;
  logic [LW-1:0]  min_len;
  logic           cfg_ok;
  logic           cnt_load;
  logic [LW-1:0]  cnt_val;
  logic           cnt_zero;
  logic           accept;
  logic           advance;
  logic           knee_en;
  logic [SW-1:0]  knee_code;

  always_comb begin
    for (int k = 0; k < NSLOPE; k++) begin
      len_arr[k] = slope_len_i[k*LW +: LW];
    end
  end

  ms_min_interval #(
    .LW      (LW),
    .UPL_PAR (UPL_PAR),
    .UPL_SER (UPL_SER)
  ) u_min (
    .gran_i   (gran_i),
    .serial_i (serial_mode_i),
    .min_o    (min_len)
  );

  ms_cfg_check #(
    .NSLOPE (NSLOPE),
    .LW     (LW)
  ) u_chk (
    .len_i  (slope_len_i),
    .last_i (slope_cnt_i),
    .min_i  (min_len),
    .ok_o   (cfg_ok)
  );

  assign nxt_idx   = idx + SW'(1);
  assign accept    = (state == SEQ_IDLE) && trig_i && cfg_ok;
  assign advance   = (state == SEQ_RUN) && cnt_zero && (idx != last);
  assign cnt_load  = accept || advance;
  assign cnt_val   = accept ? (len_arr[0] - LW'(1)) : (lat[nxt_idx] - LW'(1));
  assign knee_en   = (idx != last);
  assign knee_code = knee_en ? nxt_idx : '0;

  ms_interval_cnt #(
    .LW (LW)
  ) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .zero_o     (cnt_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      idx       <= '0;
      last      <= '0;
      wr_pend   <= 1'b0;
      start_o   <= 1'b0;
      stop_o    <= 1'b0;
      wr_req_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      busy_o    <= 1'b0;
      cfg_err_o <= 1'b0;
      for (int k = 0; k < NSLOPE; k++) lat[k] <= '0;
    end else begin
      start_o   <= 1'b0;
      stop_o    <= 1'b0;
      wr_req_o  <= 1'b0;
      cfg_err_o <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (trig_i) begin
            if (cfg_ok) begin
              start_o <= 1'b1;
              busy_o  <= 1'b1;
              lat     <= len_arr;
              last    <= slope_cnt_i;
              idx     <= '0;
              wr_pend <= (slope_cnt_i != '0);
              state   <= SEQ_RUN;
            end else begin
              cfg_err_o <= 1'b1;
            end
          end
        end
        SEQ_RUN: begin
          if (wr_pend) begin
            wr_req_o  <= 1'b1;
            wr_addr_o <= AW'(KNEE_ADDR);
            wr_data_o <= {{(DW-SW-1){1'b0}}, knee_en, knee_code};
            wr_pend   <= 1'b0;
          end
          if (cnt_zero) begin
            if (idx == last) begin
              stop_o <= 1'b1;
              state  <= SEQ_FIN;
            end else begin
              start_o <= 1'b1;
              idx     <= nxt_idx;
              wr_pend <= 1'b1;
            end
          end
        end
        SEQ_FIN: begin
          busy_o <= 1'b0;
          state  <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R3: shutter pulses are single-cycle and mutually exclusive
  p_pulse_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(start_o && stop_o));
  p_start_single_r3: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);
  p_stop_single_r3: assert property (@(posedge clk) disable iff (rst)
    stop_o |=> !stop_o);
  // R1: an exposure opens with a start pulse
  p_start_on_rise_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> start_o);
  // R4: writes only happen inside an exposure
  p_wr_in_busy_r4: assert property (@(posedge clk) disable iff (rst)
    wr_req_o |-> busy_o);
  // R5: a write never coincides with the stop pulse
  p_wr_not_stop_r5: assert property (@(posedge clk) disable iff (rst)
    wr_req_o |-> !stop_o);
  // R6: a single-slope exposure requests no writes
  p_single_no_wr_r6: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_RUN && last == '0) |-> !wr_req_o);
  // R8: a refused trigger starts nothing
  p_err_idle_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_err_o |-> (!busy_o && !start_o));
  // R9: busy ends one cycle after stop
  p_busy_fall_r9: assert property (@(posedge clk) disable iff (rst)
    stop_o |=> !busy_o);

endmodule

// File: tb/ms_shutter_seq_tb.sv
module ms_shutter_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LW  = 16;
  localparam int UPP = 40;
  localparam int UPS = 320;
  localparam int ADR = 8'h42;
  localparam int WD_LIMIT = 150000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          trig = 1'b0;
  logic [1:0]    scnt = '0;
  logic [63:0]   slen = '0;
  logic [1:0]    gran = '0;
  logic          ser  = 1'b0;
  logic          start_o, stop_o, wr_req_o, busy_o, cfg_err_o;
  logic [7:0]    wr_addr_o, wr_data_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int busy_first = -10;
  int busy_last  = -10;
  int n_start = 0, n_stop = 0, n_wr = 0;
  bit done = 0;

  bit st_at [int];
  bit sp_at [int];
  bit er_at [int];
  int wr_at [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  ms_shutter_seq #(.UPL_PAR(UPP), .UPL_SER(UPS), .KNEE_ADDR(ADR)) u_dut (
    .clk(clk), .rst(rst), .trig_i(trig), .slope_cnt_i(scnt),
    .slope_len_i(slen), .gran_i(gran), .serial_mode_i(ser),
    .start_o(start_o), .stop_o(stop_o), .wr_req_o(wr_req_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .busy_o(busy_o),
    .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input int got, input int exp, input string req, input string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: got %0d expected %0d", req, what, cyc, got, exp);
    end
  endtask

  // Reference model: schedules every event at an absolute cycle.
  always @(posedge clk) begin
    cyc++;
    if (!rst && trig && cyc > busy_last + 1) begin
      automatic int s = int'(scnt) + 1;
      automatic int mn = 5 * (32 << gran) + (ser ? UPS : UPP) + 1;
      automatic bit ok = 1;
      automatic int t = cyc;
      for (int j = 0; j < s; j++) if (int'(slen[j*16 +: 16]) < mn) ok = 0;
      if (!ok) er_at[cyc] = 1;
      else begin
        for (int j = 0; j < s; j++) begin
          st_at[t] = 1;
          if (s > 1) wr_at[t+1] = (j < s-1) ? (4 | (j+1)) : 0;
          t += int'(slen[j*16 +: 16]);
        end
        sp_at[t] = 1;
        busy_first = cyc;
        busy_last = t;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(start_o, st_at.exists(cyc), "R2", "start");
      chk(stop_o, sp_at.exists(cyc), "R2", "stop");
      chk(cfg_err_o, er_at.exists(cyc), "R8", "cfg_err");
      chk(busy_o, (cyc >= busy_first && cyc <= busy_last), "R9", "busy");
      chk(wr_req_o, wr_at.exists(cyc), "R4", "wr_req");
      if (wr_req_o && wr_at.exists(cyc)) begin
        chk(wr_data_o, wr_at[cyc], "R5", "wr_data");
        chk(wr_addr_o, ADR, "R4", "wr_addr");
      end
      n_start += int'(start_o);
      n_stop  += int'(stop_o);
      n_wr    += int'(wr_req_o);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic frame(input int s, input int l0, input int l1, input int l2,
                       input int l3, input int g, input bit sm,
                       input int exp_starts, input int exp_wr, input string req);
    n_start = 0; n_stop = 0; n_wr = 0;
    @(negedge clk);
    scnt = 2'(s - 1);
    slen = {16'(l3), 16'(l2), 16'(l1), 16'(l0)};
    gran = 2'(g);
    ser  = sm;
    pulse_trig();
    wait_idle();
    chk(n_start, exp_starts, req, "start count");
    chk(n_wr, exp_wr, req, "write count");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs low while reset is held
    chk({start_o, stop_o, wr_req_o, busy_o, cfg_err_o}, 0, "R11", "reset outputs");
    chk(wr_data_o, 0, "R11", "reset data");
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 R4 R5 R7: four slopes, first one exactly at the minimum (201)
    frame(4, 201, 250, 300, 220, 0, 0, 4, 4, "R4");
    // R7 R8: one below the minimum is refused
    frame(4, 200, 250, 300, 220, 0, 0, 0, 0, "R8");
    // R6 R8: single slope, short unused slopes ignored
    frame(1, 210, 3, 3, 3, 0, 0, 1, 0, "R6");
    // R7: serial interface, gran 1: minimum 641
    frame(2, 641, 700, 0, 0, 1, 1, 2, 2, "R7");
    frame(3, 700, 700, 640, 0, 1, 1, 0, 0, "R7");
    // R7: gran 3 parallel: minimum 1321
    frame(3, 1321, 1400, 1500, 0, 3, 0, 3, 3, "R5");

    // R9 R10: retrigger and input change mid-exposure
    n_start = 0; n_wr = 0;
    @(negedge clk);
    scnt = 2'd2; slen = {16'd0, 16'd400, 16'd300, 16'd250}; gran = 2'd0; ser = 1'b0;
    pulse_trig();
    repeat (50) @(negedge clk);
    scnt = 2'd0; slen = {16'd5, 16'd5, 16'd5, 16'd5};
    pulse_trig();
    wait_idle();
    chk(n_start, 3, "R10", "start count after change");
    chk(n_wr, 3, "R9", "write count after retrigger");
    // R1: back-to-back acceptance right after busy drops
    frame(2, 300, 300, 0, 0, 0, 0, 2, 2, "R1");

    finish_run();
  end

endmodule